// File: doc/BRIEF.md
# Subset-Checksum Encoder for Three Parallel 2-of-4 Channels

This block maps six data bits per clock onto three parallel four-wire channels. Every wire group carries a constant-weight symbol with exactly two ones set. The six 2-of-4 symbols are paired into three subsets, and the two members of a subset are bitwise complements of each other. The subset a channel uses is chosen by a base-3 digit, and the member within that subset is chosen by one plain data bit.

Three of the input bits form a value from 0 to 7. That value is split into two base-3 digits. A third base-3 digit is added as a checksum, so that the three digits sum to zero modulo 3. The three remaining input bits each choose the member for one channel. A receiver can therefore use the subset information and the checksum to find a damaged symbol and repair it. Twelve wires carry six data bits, and the protection needs no extra wire.

The encoder has one register stage. A valid strobe travels through it alongside the data. When no new input is valid, the symbol outputs keep their last value.

Top module: `subset_sum_encoder`

## Requirements
- R1: After a clock edge with rst_n low, out_valid is 0 and all three symbol outputs are 4'b0000.
- R2: out_valid equals the in_valid that was sampled at the previous clock edge. The symbols for an input accepted at one edge appear after that same edge, so the latency is one cycle.
- R3: Whenever out_valid is 1, each of out_sym0, out_sym1 and out_sym2 has exactly two bits set.
- R4: With v = in_data[2:0], out_sym0 carries subset index v / 3 (integer division) and out_sym1 carries subset index v mod 3.
- R5: out_sym2 carries a subset index p chosen so that (v/3 + v mod 3 + p) mod 3 = 0.
- R6: The subset index encoding, written as sym[3:0], is as follows: index 0 is {0011, 1100}, index 1 is {0101, 1010}, and index 2 is {0110, 1001}. For channel k, in_data[3+k] = 0 selects the first member and in_data[3+k] = 1 selects the second.
- R7: Toggling only in_data[3+k] complements out_symk, which is a Hamming distance of 4, and leaves the other two channels unchanged.
- R8: A clock edge with in_valid low leaves all three symbol outputs unchanged, whatever value in_data has.
- R9: All 64 input words produce 64 distinct 12-bit output code words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | 6 | [2:0] value for the checksum digits, [5:3] member selects for channels 0 to 2 |
| out_valid | output | 1 | Symbol outputs hold a fresh code word |
| out_sym0 | output | 4 | Channel 0 symbol (digit v/3) |
| out_sym1 | output | 4 | Channel 1 symbol (digit v mod 3) |
| out_sym2 | output | 4 | Channel 2 symbol (checksum digit) |

## Verification
The bench drives all 64 input words and checks each code word against subsets and checksum digits that it computes itself.

**Digit split.** Values 6 and 7 are the only ones whose first digit is 2. A wrong digit split shows up there as a bad channel 0 symbol, or as a checksum that breaks the sum.

**Checksum when the digit sum is 0.** Values such as 0 and 5 make the digit sum divisible by 3. The parity digit must then be 0, not 3 left unreduced, and a missing reduction gives a symbol outside the alphabet.

**Member select.** Toggling each member-select bit on its own must complement only its own channel. This catches swapped members, crossed channels and a low-level bit that leaks into the checksum.

**Hold when idle.** Idle cycles drive inverted data while in_valid is low. A design that loads its output register unconditionally then shows changed symbols.

// File: rtl/sse_pkg.sv
// Package: shared constants, types and the subset alphabet for the
// subset-checksum encoder. Assumes a 2-of-4 alphabet split into three
// complementary pairs, one pair per base-3 digit value.
package sse_pkg;

    localparam int NUM_CH   = 3;                 // parallel channels
    localparam int SYM_W    = 4;                 // wires per channel
    localparam int DIG_W    = 2;                 // bits per base-3 digit
    localparam int HL_W     = 3;                 // high-level value bits
    localparam int LL_W     = NUM_CH;            // one member select per channel
    localparam int DATA_W   = HL_W + LL_W;       // total data bits per word
    localparam int RADIX    = 3;                 // digit base

    typedef logic [DIG_W-1:0] digit_t;
    typedef logic [SYM_W-1:0] sym_t;

    // First member of the subset named by a digit; the second member is
    // its bitwise complement.
    function automatic sym_t subset_first(input digit_t d);
        sym_t s;
        unique case (d)
            2'd0:    s = 4'b0011;
            2'd1:    s = 4'b0101;
            default: s = 4'b0110;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sse_digit_split.sv
// Module: splits the high-level value into two base-3 digits.
// Assumes the value is below RADIX*RADIX, so both digits stay below RADIX.
module sse_digit_split
    import sse_pkg::*;
(
    input  logic [HL_W-1:0] value,
    output digit_t          dig_hi,
    output digit_t          dig_lo
);

    localparam logic [HL_W-1:0] R = HL_W'(RADIX);

    logic [HL_W-1:0] quot;
    logic [HL_W-1:0] rem;

    // Integer divide and remainder by the radix.
    always_comb begin
        quot   = value / R;
        rem    = value % R;
        dig_hi = DIG_W'(quot);
        dig_lo = DIG_W'(rem);
    end

endmodule

// File: rtl/sse_parity.sv
// Module: computes the base-3 checksum digit that brings the digit sum
// to zero modulo the radix. Assumes both input digits are below RADIX.
module sse_parity
    import sse_pkg::*;
(
    input  digit_t dig_a,
    input  digit_t dig_b,
    output digit_t dig_p
);

    logic [DIG_W:0] sum;
    logic [DIG_W:0] sum_mod;

    // Reduce the sum of two digits, then take its additive inverse.
    always_comb begin
        sum     = {1'b0, dig_a} + {1'b0, dig_b};
        sum_mod = (sum >= (DIG_W+1)'(RADIX)) ? sum - (DIG_W+1)'(RADIX) : sum;
        dig_p   = (sum_mod == '0) ? '0 : DIG_W'((DIG_W+1)'(RADIX) - sum_mod);
    end

endmodule

// File: rtl/sse_symbol_map.sv
// Module: maps a subset digit and a member-select bit to a 2-of-4 symbol.
// Assumes the digit is below RADIX; a select of 1 picks the complement.
module sse_symbol_map
    import sse_pkg::*;
(
    input  digit_t dig,
    input  logic   sel,
    output sym_t   sym
);

    // Pick the subset's first member and complement it on select.
    always_comb begin
        sym = subset_first(dig) ^ {SYM_W{sel}};
    end

endmodule

// File: rtl/subset_sum_encoder.sv
// Module: top of the subset-checksum encoder. Takes a 6-bit word per
// valid cycle and registers three 2-of-4 symbols one cycle later.
// Assumes a synchronous active-low reset; the symbols hold when idle.
module subset_sum_encoder
    import sse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [SYM_W-1:0]  out_sym0,
    output logic [SYM_W-1:0]  out_sym1,
    output logic [SYM_W-1:0]  out_sym2
);

    digit_t          digits [NUM_CH];
    sym_t            sym_d  [NUM_CH];
    sym_t            sym_q  [NUM_CH];
    logic [LL_W-1:0] member_sel;
    logic            valid_q;

    assign member_sel = in_data[DATA_W-1:HL_W];

    sse_digit_split u_split (
        .value  (in_data[HL_W-1:0]),
        .dig_hi (digits[0]),
        .dig_lo (digits[1])
    );

    sse_parity u_parity (
        .dig_a (digits[0]),
        .dig_b (digits[1]),
        .dig_p (digits[2])
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        sse_symbol_map u_map (
            .dig (digits[k]),
            .sel (member_sel[k]),
            .sym (sym_d[k])
        );

        // Capture this channel's symbol on valid input; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sym_q[k] <= '0;
            else if (in_valid)
                sym_q[k] <= sym_d[k];
        end
    end

    // Carry the valid strobe alongside the registered symbols.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid_q <= 1'b0;
        else
            valid_q <= in_valid;
    end

    assign out_valid = valid_q;
    assign out_sym0  = sym_q[0];
    assign out_sym1  = sym_q[1];
    assign out_sym2  = sym_q[2];

endmodule

// File: rtl/sse_checker.sv
// Module: property checker for the subset-checksum encoder, bound to the top.
// Assumes the ports of the top module only.
module sse_checker
    import sse_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic [SYM_W-1:0]  out_sym0,
    input logic [SYM_W-1:0]  out_sym1,
    input logic [SYM_W-1:0]  out_sym2
);

    function automatic int unsigned sym_index(input logic [SYM_W-1:0] s);
        if (s == 4'b0011 || s == 4'b1100) return 0;
        if (s == 4'b0101 || s == 4'b1010) return 1;
        return 2;
    endfunction

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_weight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_sym0) == 2 && $countones(out_sym1) == 2
                       && $countones(out_sym2) == 2));

    p_checksum_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((sym_index(out_sym0) + sym_index(out_sym1)
                        + sym_index(out_sym2)) % 3 == 0));

    p_member_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_sym0[3] == $past(in_data[3]) && out_sym1[3] == $past(in_data[4])
                      && out_sym2[3] == $past(in_data[5])));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_sym0) && $stable(out_sym1) && $stable(out_sym2)));

endmodule

bind subset_sum_encoder sse_checker u_sse_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_sym0  (out_sym0),
    .out_sym1  (out_sym1),
    .out_sym2  (out_sym2)
);

// File: tb/subset_sum_encoder_test.sv
// Bench: exhaustive sweep of all 64 input words with arithmetic expectations.
module subset_sum_encoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [5:0] in_data;
    logic       out_valid;
    logic [3:0] out_sym0, out_sym1, out_sym2;

    int checks = 0;
    int errors = 0;
    logic [11:0] codes [64];
    bit          seen  [4096];

    always #(CLK_PERIOD/2) clk = ~clk;

    subset_sum_encoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_sym0(out_sym0), .out_sym1(out_sym1),
        .out_sym2(out_sym2)
    );

    function automatic logic [3:0] exp_sym(input int idx, input bit sel);
        logic [3:0] b;
        b = (idx == 0) ? 4'b0011 : (idx == 1) ? 4'b0101 : 4'b0110;
        return sel ? ~b : b;
    endfunction

    function automatic logic [11:0] exp_word(input int d);
        int v, a, b, p;
        v = d % 8; a = v / 3; b = v % 3; p = (3 - (a + b) % 3) % 3;
        return {exp_sym(p, d[5]), exp_sym(b, d[4]), exp_sym(a, d[3])};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; in_data = 6'h3f;
        repeat (2) @(negedge clk);
        check("R1 valid", 32'(out_valid), 0);
        check("R1 symbols", 32'({out_sym2, out_sym1, out_sym0}), 0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);

        for (int d = 0; d < 64; d++) begin
            logic [11:0] w;
            w = exp_word(d);
            in_valid = 1'b1; in_data = 6'(d);
            @(negedge clk);
            check("R2 valid", 32'(out_valid), 1);
            check("R4 sym0", 32'(out_sym0), 32'(w[3:0]));
            check("R4 sym1", 32'(out_sym1), 32'(w[7:4]));
            check("R5 sym2", 32'(out_sym2), 32'(w[11:8]));
            check("R3 weight", $countones({out_sym2, out_sym1, out_sym0}), 6);
            check("R6 sel bits", 32'({out_sym2[3], out_sym1[3], out_sym0[3]}), 32'(d >> 3));
            codes[d] = {out_sym2, out_sym1, out_sym0};
            // idle cycle with changed data: symbols must hold
            in_valid = 1'b0; in_data = ~6'(d);
            @(negedge clk);
            check("R2 idle", 32'(out_valid), 0);
            check("R8 hold", 32'({out_sym2, out_sym1, out_sym0}), 32'(w));
        end

        for (int d = 0; d < 64; d++) begin
            check("R9 distinct", 32'(seen[codes[d]]), 0);
            seen[codes[d]] = 1'b1;
            for (int k = 0; k < 3; k++) begin
                logic [11:0] diff;
                diff = codes[d] ^ codes[d ^ (8 << k)];
                check("R7 toggle", 32'(diff), 32'(12'hf << (4 * k)));
            end
        end
        finish_run();
    end

endmodule